// File: doc/BRIEF.md
# Bit-6 Address Swizzle Unit

This block is for tiled surfaces stored in dual-channel interleaved memory. On that memory the channel select follows address bit 6, and tiled accesses also change channel on some higher address bits. The address path takes a byte address, a tile layout (X or Y) and a configured swizzle mode. It returns the same address with bit 6 replaced by the XOR of bit 6 and a set of higher bits. The mode and the tile layout together choose that set. The result is registered, and a valid bit travels with it.

The second path repairs page contents. When a page lands at a physical location whose bit 17 differs from the bit 17 it had when it was written, the two 64-byte halves of every 128-byte chunk trade places. The page streams through as 64-bit words under a valid/ready handshake. When the two bit-17 values sampled for the page differ, the halves are exchanged, using one 64-byte holding buffer. When they are equal, the words pass through in order.

Top module: `swz_unit`

## Requirements
- R1: `addr_out_valid` is high exactly one clock after a cycle with `addr_in_valid` high, and low one clock after a cycle with it low.
- R2: The transformed address differs from the input address in bit 6 at most.
- R3: Mode code 0 (no swizzle) returns the address unchanged and keeps `swz_unknown` low.
- R4: With X tiling (`tile_y`=0), bit 6 is XORed with: bit 9 for code 1, bits 9 and 10 for code 2, bits 9, 10 and 11 for code 4, and bits 9, 10 and 17 for code 6.
- R5: With Y tiling (`tile_y`=1), bit 10 drops out of the set: codes 1 and 2 use bit 9 only, code 4 uses bits 9 and 11, and code 6 uses bits 9 and 17.
- R6: Code 3 XORs bits 9 and 11 and code 5 XORs bits 9 and 17, for either tile layout.
- R7: Code 7 (unknown) returns the address unchanged and raises `swz_unknown` together with that result. `swz_unknown` is low for every other code.
- R8: While reset is held, `addr_out_valid`, `swz_unknown` and `fix_out_valid` are low, provided `fix_in_valid` is low.
- R9: A page is 512 words of 64 bits (4 KiB), and its first accepted word is word 0. If `pg_old_b17` differs from `pg_new_b17` on that first word, output word k of each 16-word chunk carries input word k XOR 8 of that chunk.
- R10: If the two bit-17 inputs are equal on the first word, the page leaves in input order, unmodified.
- R11: While `fix_out_valid` is high and `fix_out_ready` is low, `fix_out_valid` stays high and `fix_out_data` stays the same in the next cycle.
- R12: The bit-17 inputs are sampled only on a page's first accepted word. Changes on later words of that page have no effect on its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in_valid | input | 1 | Address request valid |
| addr_in | input | AW | Byte address to transform |
| tile_y | input | 1 | Tile layout: 0 = X, 1 = Y |
| swz_mode | input | 3 | Swizzle mode code, 0 to 7 |
| addr_out_valid | output | 1 | Transformed address valid |
| addr_out | output | AW | Transformed address |
| swz_unknown | output | 1 | Mode code 7 was seen for this result |
| pg_old_b17 | input | 1 | Bit 17 recorded for the page when it was saved |
| pg_new_b17 | input | 1 | Bit 17 of the page's new location |
| fix_in_valid | input | 1 | Input word valid |
| fix_in_data | input | WORD_W | Input page word |
| fix_in_ready | output | 1 | Input word accepted when high with valid |
| fix_out_valid | output | 1 | Output word valid |
| fix_out_data | output | WORD_W | Output page word |
| fix_out_ready | input | 1 | Downstream accepts output word |

## Verification
The address result appears one clock after its request. The bench drives each request on a falling edge and compares the result at the next falling edge, after the single capturing rising edge. The fix-up path has no fixed latency because of the handshake. The bench therefore samples both handshakes shortly after each falling edge, counts transfers on each side, and derives the expected value of every output word from its position in the page and that page's swap decision. Stalled outputs are compared again one cycle later, which covers the hold rule.

// File: rtl/swz_pkg.sv
package swz_pkg;

    typedef enum logic [2:0] {
        SWZ_NONE     = 3'd0,
        SWZ_9        = 3'd1,
        SWZ_9_10     = 3'd2,
        SWZ_9_11     = 3'd3,
        SWZ_9_10_11  = 3'd4,
        SWZ_9_17     = 3'd5,
        SWZ_9_10_17  = 3'd6,
        SWZ_UNKNOWN  = 3'd7
    } swz_mode_e;

    typedef struct packed {
        logic use9;
        logic use10;
        logic use11;
        logic use17;
    } swz_sel_t;

    typedef enum logic {
        FX_STREAM = 1'b0,
        FX_DRAIN  = 1'b1
    } fix_state_e;

    localparam int HALF_BYTES = 64;

    // Y tiling walks rows of 128 bytes, so bit 10 never joins the set.
    function automatic swz_sel_t swz_decode(input swz_mode_e m, input logic tile_y);
        swz_sel_t s;
        s = '0;
        case (m)
            SWZ_9:       s.use9 = 1'b1;
            SWZ_9_10:    begin s.use9 = 1'b1; s.use10 = !tile_y; end
            SWZ_9_11:    begin s.use9 = 1'b1; s.use11 = 1'b1; end
            SWZ_9_10_11: begin s.use9 = 1'b1; s.use10 = !tile_y; s.use11 = 1'b1; end
            SWZ_9_17:    begin s.use9 = 1'b1; s.use17 = 1'b1; end
            SWZ_9_10_17: begin s.use9 = 1'b1; s.use10 = !tile_y; s.use17 = 1'b1; end
            default:     s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/swz_addr_xor.sv
module swz_addr_xor
    import swz_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    input  logic          tile_y,
    input  swz_mode_e     mode,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic          unknown
);
    swz_sel_t      sel;
    logic          flip;
    logic [AW-1:0] nxt_addr;

    always_comb begin
        sel  = swz_decode(mode, tile_y);
        flip = (sel.use9  & in_addr[9])  ^ (sel.use10 & in_addr[10]) ^
               (sel.use11 & in_addr[11]) ^ (sel.use17 & in_addr[17]);
        nxt_addr    = in_addr;
        nxt_addr[6] = in_addr[6] ^ flip;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            unknown   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_addr <= nxt_addr;
                unknown  <= (mode == SWZ_UNKNOWN);
            end
        end
    end
endmodule

// File: rtl/swz_chunk_buf.sv
module swz_chunk_buf #(
    parameter int W     = 64,
    parameter int DEPTH = 8,
    localparam int AWB  = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           we,
    input  logic [AWB-1:0] waddr,
    input  logic [W-1:0]   wdata,
    input  logic [AWB-1:0] raddr,
    output logic [W-1:0]   rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/swz_page_fixup.sv
module swz_page_fixup
    import swz_pkg::*;
#(
    parameter int WORD_W     = 64,
    parameter int PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              old_b17,
    input  logic              new_b17,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    input  logic              out_ready
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int HALF_WORDS = HALF_BYTES / WORD_BYTES;
    localparam int PAGE_WORDS = PAGE_BYTES / WORD_BYTES;
    localparam int HW         = $clog2(HALF_WORDS);
    localparam int CW         = HW + 1;
    localparam int PW         = $clog2(PAGE_WORDS);
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_WORDS - 1);

    fix_state_e        st;
    logic [PW-1:0]     in_cnt;
    logic              swap_q;
    logic [HW-1:0]     drain_idx;
    logic              page_first;
    logic              swap_now;
    logic [CW-1:0]     chunk_off;
    logic              upper_half;
    logic [HW-1:0]     half_idx;
    logic              buf_we;
    logic [WORD_W-1:0] buf_rdata;
    logic              accept;

    assign page_first = (in_cnt == '0);
    assign swap_now   = page_first ? (old_b17 ^ new_b17) : swap_q;
    assign chunk_off  = in_cnt[CW-1:0];
    assign upper_half = chunk_off[CW-1];
    assign half_idx   = chunk_off[HW-1:0];

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = in_data;
        buf_we    = 1'b0;
        if (st == FX_DRAIN) begin
            out_valid = 1'b1;
            out_data  = buf_rdata;
        end else if (!swap_now || upper_half) begin
            out_valid = in_valid;
            in_ready  = out_ready;
        end else begin
            in_ready = 1'b1;
            buf_we   = in_valid;
        end
    end

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= FX_STREAM;
            in_cnt    <= '0;
            swap_q    <= 1'b0;
            drain_idx <= '0;
        end else begin
            if (accept) begin
                in_cnt <= in_cnt + 1'b1;
                if (page_first) swap_q <= old_b17 ^ new_b17;
                if (swap_now && upper_half && half_idx == HALF_LAST) begin
                    st        <= FX_DRAIN;
                    drain_idx <= '0;
                end
            end
            if (st == FX_DRAIN && out_ready) begin
                drain_idx <= drain_idx + 1'b1;
                if (drain_idx == HALF_LAST) st <= FX_STREAM;
            end
        end
    end

    swz_chunk_buf #(.W(WORD_W), .DEPTH(HALF_WORDS)) i_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (half_idx),
        .wdata (in_data),
        .raddr (drain_idx),
        .rdata (buf_rdata)
    );
endmodule

// File: rtl/swz_unit.sv
module swz_unit
    import swz_pkg::*;
#(
    parameter int AW         = 32,
    parameter int WORD_W     = 64,
    parameter int PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_in_valid,
    input  logic [AW-1:0]     addr_in,
    input  logic              tile_y,
    input  logic [2:0]        swz_mode,
    output logic              addr_out_valid,
    output logic [AW-1:0]     addr_out,
    output logic              swz_unknown,
    input  logic              pg_old_b17,
    input  logic              pg_new_b17,
    input  logic              fix_in_valid,
    input  logic [WORD_W-1:0] fix_in_data,
    output logic              fix_in_ready,
    output logic              fix_out_valid,
    output logic [WORD_W-1:0] fix_out_data,
    input  logic              fix_out_ready
);
    swz_addr_xor #(.AW(AW)) i_addr (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (addr_in_valid),
        .in_addr   (addr_in),
        .tile_y    (tile_y),
        .mode      (swz_mode_e'(swz_mode)),
        .out_valid (addr_out_valid),
        .out_addr  (addr_out),
        .unknown   (swz_unknown)
    );

    swz_page_fixup #(.WORD_W(WORD_W), .PAGE_BYTES(PAGE_BYTES)) i_fix (
        .clk       (clk),
        .rst       (rst),
        .old_b17   (pg_old_b17),
        .new_b17   (pg_new_b17),
        .in_valid  (fix_in_valid),
        .in_data   (fix_in_data),
        .in_ready  (fix_in_ready),
        .out_valid (fix_out_valid),
        .out_data  (fix_out_data),
        .out_ready (fix_out_ready)
    );
endmodule

// File: rtl/swz_unit_checker.sv
module swz_unit_checker #(
    parameter int AW     = 32,
    parameter int WORD_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              addr_in_valid,
    input logic [AW-1:0]     addr_in,
    input logic [2:0]        swz_mode,
    input logic              addr_out_valid,
    input logic [AW-1:0]     addr_out,
    input logic              swz_unknown,
    input logic              fix_out_valid,
    input logic [WORD_W-1:0] fix_out_data,
    input logic              fix_out_ready
);
    localparam logic [AW-1:0] BIT6 = AW'(1) << 6;

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (addr_out_valid == $past(addr_in_valid)));

    assert_only_bit6_R2: assert property (@(posedge clk) disable iff (rst)
        (addr_out_valid && !$past(rst)) |-> (((addr_out ^ $past(addr_in)) & ~BIT6) == '0));

    assert_none_pass_R3: assert property (@(posedge clk) disable iff (rst)
        (addr_out_valid && !$past(rst) && $past(swz_mode) == 3'd0)
        |-> (addr_out == $past(addr_in) && !swz_unknown));

    assert_unknown_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (addr_out_valid && !$past(rst)) |-> (swz_unknown == ($past(swz_mode) == 3'd7)));

    assert_unknown_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (addr_out_valid && swz_unknown) |-> (addr_out == $past(addr_in)));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (fix_out_valid && !fix_out_ready) |=> (fix_out_valid && $stable(fix_out_data)));
endmodule

bind swz_unit swz_unit_checker #(.AW(AW), .WORD_W(WORD_W)) i_chk (
    .clk            (clk),
    .rst            (rst),
    .addr_in_valid  (addr_in_valid),
    .addr_in        (addr_in),
    .swz_mode       (swz_mode),
    .addr_out_valid (addr_out_valid),
    .addr_out       (addr_out),
    .swz_unknown    (swz_unknown),
    .fix_out_valid  (fix_out_valid),
    .fix_out_data   (fix_out_data),
    .fix_out_ready  (fix_out_ready)
);

// File: tb/test_swz_unit.sv
`timescale 1ns/1ps
module test_swz_unit;
    localparam int AW = 32;
    localparam int WW = 64;
    localparam int PAGE_WORDS = 512;
    localparam int NPAGES = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          addr_in_valid = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          tile_y = 1'b0;
    logic [2:0]    swz_mode = 3'd0;
    logic          addr_out_valid;
    logic [AW-1:0] addr_out;
    logic          swz_unknown;
    logic          pg_old_b17 = 1'b0;
    logic          pg_new_b17 = 1'b0;
    logic          fix_in_valid = 1'b0;
    logic [WW-1:0] fix_in_data = '0;
    logic          fix_in_ready;
    logic          fix_out_valid;
    logic [WW-1:0] fix_out_data;
    logic          fix_out_ready = 1'b0;

    int n_checks = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    swz_unit #(.AW(AW), .WORD_W(WW), .PAGE_BYTES(4096)) i_swz_unit (
        .clk(clk), .rst(rst),
        .addr_in_valid(addr_in_valid), .addr_in(addr_in), .tile_y(tile_y),
        .swz_mode(swz_mode), .addr_out_valid(addr_out_valid), .addr_out(addr_out),
        .swz_unknown(swz_unknown), .pg_old_b17(pg_old_b17), .pg_new_b17(pg_new_b17),
        .fix_in_valid(fix_in_valid), .fix_in_data(fix_in_data), .fix_in_ready(fix_in_ready),
        .fix_out_valid(fix_out_valid), .fix_out_data(fix_out_data),
        .fix_out_ready(fix_out_ready)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a,
                                               input logic [2:0] m, input logic y);
        logic t;
        case (m)
            3'd1: t = a[9];
            3'd2: t = y ? a[9] : (a[9] ^ a[10]);
            3'd3: t = a[9] ^ a[11];
            3'd4: t = y ? (a[9] ^ a[11]) : (a[9] ^ a[10] ^ a[11]);
            3'd5: t = a[9] ^ a[17];
            3'd6: t = y ? (a[9] ^ a[17]) : (a[9] ^ a[10] ^ a[17]);
            default: t = 1'b0;
        endcase
        return a ^ (AW'(t) << 6);
    endfunction

    function automatic string mode_tag(input logic [2:0] m, input logic y);
        if (m == 3'd0) return "R3";
        if (m == 3'd7) return "R7";
        if (m == 3'd3 || m == 3'd5) return "R6";
        return y ? "R5" : "R4";
    endfunction

    task automatic addr_case(input logic [AW-1:0] a, input logic [2:0] m, input logic y);
        logic [AW-1:0] e;
        @(negedge clk);
        addr_in_valid = 1'b1;
        addr_in = a;
        swz_mode = m;
        tile_y = y;
        e = exp_addr(a, m, y);
        @(negedge clk);
        addr_in_valid = 1'b0;
        check(addr_out_valid == 1'b1, "R1 valid", 64'(addr_out_valid), 64'd1);
        check(addr_out == e, mode_tag(m, y), 64'(addr_out), 64'(e));
        check(((addr_out ^ a) & ~(AW'(1) << 6)) == '0, "R2 other bits", 64'(addr_out), 64'(a));
        check(swz_unknown == (m == 3'd7), "R7 flag", 64'(swz_unknown), 64'(m == 3'd7));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        bit stalled;
        logic [WW-1:0] stall_data;
        bit acc;
        int pg_in, w_in, pg_out, w_out, src;
        bit sw;
        logic [2:0] mrand;
        logic yrand;
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check(addr_out_valid == 1'b0, "R8 addr_out_valid", 64'(addr_out_valid), 64'd0);
        check(swz_unknown == 1'b0, "R8 swz_unknown", 64'(swz_unknown), 64'd0);
        check(fix_out_valid == 1'b0, "R8 fix_out_valid", 64'(fix_out_valid), 64'd0);
        rst = 1'b0;

        // directed corners: every mode, both tilings, all relevant bits set
        for (int m = 0; m < 8; m++) begin
            for (int y = 0; y < 2; y++) begin
                addr_case(32'h0002_0E00, 3'(m), 1'(y));
                addr_case(32'h0002_0640, 3'(m), 1'(y));
                addr_case(32'hFFFF_FFBF, 3'(m), 1'(y));
            end
        end
        // idle cycle: R1 valid must fall
        @(negedge clk);
        check(addr_out_valid == 1'b0, "R1 idle", 64'(addr_out_valid), 64'd0);

        for (int i = 0; i < 400; i++) begin
            mrand = 3'($urandom % 8);
            yrand = 1'($urandom % 2);
            addr_case($urandom, mrand, yrand);
        end

        // page fix-up stream: pages 0..3 use bit-17 pairs 00, 01, 10, 11
        pg_in = 0; w_in = 0; pg_out = 0; w_out = 0;
        acc = 1'b0; stalled = 1'b0; stall_data = '0;
        while (pg_out < NPAGES) begin
            @(negedge clk);
            if (acc) begin
                fix_in_valid = 1'b0;
                w_in++;
                if (w_in == PAGE_WORDS) begin w_in = 0; pg_in++; end
            end
            if (!fix_in_valid && pg_in < NPAGES && ($urandom % 4) != 0) begin
                fix_in_valid = 1'b1;
                fix_in_data = {32'(pg_in), 32'(w_in)};
            end
            if (fix_in_valid && w_in == 0) begin
                pg_old_b17 = pg_in[1];
                pg_new_b17 = pg_in[0];
            end else begin
                // R12: noise on later words must not matter
                pg_old_b17 = 1'($urandom % 2);
                pg_new_b17 = 1'($urandom % 2);
            end
            fix_out_ready = (($urandom % 4) != 0);
            #1;
            if (stalled) begin
                check(fix_out_valid && fix_out_data == stall_data, "R11 hold",
                      fix_out_data, stall_data);
            end
            acc = fix_in_valid && fix_in_ready;
            stalled = fix_out_valid && !fix_out_ready;
            stall_data = fix_out_data;
            if (fix_out_valid && fix_out_ready) begin
                sw = (pg_out == 1) || (pg_out == 2);
                src = sw ? (w_out ^ 8) : w_out;
                check(fix_out_data == {32'(pg_out), 32'(src)},
                      sw ? "R9 R12 swapped word" : "R10 R12 in-order word",
                      fix_out_data, {32'(pg_out), 32'(src)});
                w_out++;
                if (w_out == PAGE_WORDS) begin w_out = 0; pg_out++; end
            end
        end
        @(negedge clk);
        fix_in_valid = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule